// File: doc/BRIEF.md
# Channel-Sweep Convolution Engine

This block computes one stride-1, unpadded 2D convolution layer followed by a per-channel bias and a rectifier. Each weight is fetched once and then applied to every output pixel of the current output channel before the next weight is fetched. Running partial sums live in an on-chip buffer that has one entry per output pixel. With the output plane swept innermost, any buffer entry is revisited only once per plane. A deep multiply-accumulate pipeline can therefore issue one operation every clock with no read-after-write conflict.

The layer shape is given on configuration inputs and is captured when a start pulse arrives at an idle engine. The engine reads feature-map, weight and bias values from three external synchronous memories and writes rectified, saturated results to an output memory. A one-clock done pulse marks the end of the layer. When the output plane is smaller than the pipeline, the engine stalls before starting the next sweep until the oldest update to the first pixel has landed.

Top module: `conv_sweep_engine`

## Requirements
- R1: After a synchronous active-low reset the engine is idle, with `done` low and `out_we` low.
- R2: Output height and width are `cfg_in_h-cfg_k+1` and `cfg_in_w-cfg_k+1`, with P as their product. The feature address of a tap is `(ic*in_h + row+ky)*in_w + col+kx`. The weight address is `((oc*in_ch+ic)*k+ky)*k+kx`. The bias address is `oc`. Output pixel (row,col) of channel oc is written to address `oc*P + row*out_w + col`.
- R3: The partial-sum buffer is cleared at the start of every output channel, so each channel's result depends only on its own weights and bias.
- R4: Loops nest as output channel, input channel, kernel row, kernel column, output column and output row (innermost). With P of at least LAT-1, where LAT=14 is the accumulate latency, the layer takes exactly 1 + out_ch*(1 + T*(P+2) + LAT+1 + 2 + P) cycles from the start cycle to the done cycle, with T = in_ch*k*k.
- R5: When P is smaller than the pipeline depth, the engine holds off a new sweep until the last update of the entry it will read has been written. Results stay exact down to P=1.
- R6: Each output is the accumulated sum plus the channel bias. Any value less than or equal to zero is written as 0.
- R7: Operands are signed 16-bit integers. Products are kept at full precision and accumulated in 40 bits with no shift. A positive result above 32767 is written as 32767.
- R8: Start and the configuration are sampled only in the idle state. A start pulse during a layer changes neither the running layer nor its results, and produces no extra done pulse.
- R9: Every output address of the layer is written exactly once. `done` is high for exactly one clock, in the cycle after the last write.
- R10: All three read memories are synchronous, with data returned the cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a layer (idle only) |
| cfg_in_h | input | 8 | Input height |
| cfg_in_w | input | 8 | Input width |
| cfg_in_ch | input | 8 | Input channels |
| cfg_k | input | 8 | Square kernel size |
| cfg_out_ch | input | 8 | Output channels |
| fm_addr | output | 16 | Feature-map read address |
| fm_rdata | input | 16 | Feature-map read data (next cycle) |
| wt_addr | output | 16 | Weight read address |
| wt_rdata | input | 16 | Weight read data (next cycle) |
| bias_addr | output | 8 | Bias read address |
| bias_rdata | input | 16 | Bias read data (next cycle) |
| out_we | output | 1 | Output write strobe |
| out_addr | output | 16 | Output write address |
| out_wdata | output | 16 | Rectified, saturated result |
| done | output | 1 | One-cycle end-of-layer pulse |

## Verification
The bench targets small output planes down to a single pixel. There, a missing stall would let a sweep read an entry before its previous update lands, and the affected outputs would lose earlier kernel taps. Multi-channel layers expose a buffer that is not cleared between channels, which would carry one channel's sums into the next. Full-scale positive and negative operands check saturation and the rectifier, where a bad design would wrap to a wrong sign. A start pulse with a different shape in mid-layer shows whether the engine re-captures its configuration, which would corrupt addresses and add a second done. An exact cycle count on a large plane catches lost issue slots or an extra drain cycle.

// File: rtl/conv_pkg.sv
// Shared types for the channel-sweep convolution engine.
package conv_pkg;
    // Controller sequencing states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_WADDR,
        ST_WLATCH,
        ST_SWEEP,
        ST_DRAIN,
        ST_BADDR,
        ST_BLATCH,
        ST_WRITE,
        ST_DONE
    } eng_state_t;
endpackage

// File: rtl/conv_psum_buf.sv
// Partial-sum store: one accumulator entry per output pixel.
// Assumes the clear is only requested while no write-back is in flight.
module conv_psum_buf #(
    parameter int ACC_W   = 40,
    parameter int MAX_PIX = 64,
    localparam int IDX_W  = $clog2(MAX_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_v,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACC_W-1:0] wr_acc,
    input  logic [IDX_W-1:0] rda_idx,
    output logic [ACC_W-1:0] rda_acc,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic [ACC_W-1:0] rdb_acc
);
    logic [ACC_W-1:0] mem_q [MAX_PIX];

    // Clear every entry at once or apply one pipeline write-back.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < MAX_PIX; i++) mem_q[i] <= '0;
        end else if (wr_v) begin
            mem_q[wr_idx] <= wr_acc;
        end
    end

    // Two combinational read ports: issue side and write-out side.
    always_comb begin
        rda_acc = mem_q[rda_idx];
        rdb_acc = mem_q[rdb_idx];
    end

    // Clearing while an update is landing would lose or corrupt a sum.
    assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !wr_v);
endmodule

// File: rtl/conv_mac_pipe.sv
// Multiply-accumulate pipeline of LAT stages. Stage 1 captures the issued
// index and old partial sum while the feature read returns, stage 2 adds the
// product, the rest only delay. Assumes LAT >= 2.
module conv_mac_pipe #(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int MAX_PIX = 64,
    parameter int LAT     = 14,
    localparam int IDX_W  = $clog2(MAX_PIX),
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_v,
    input  logic [IDX_W-1:0]         issue_idx,
    input  logic [ACC_W-1:0]         old_acc,
    input  logic signed [DATA_W-1:0] fm_rdata,
    input  logic signed [DATA_W-1:0] wq,
    output logic                     wr_v,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [ACC_W-1:0]         wr_acc,
    output logic                     busy
);
    logic             v_q   [1:LAT];
    logic [IDX_W-1:0] idx_q [1:LAT];
    logic [ACC_W-1:0] acc_q [2:LAT];
    logic [ACC_W-1:0] old_q;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0] prod_ext;

    // Full-precision product, sign-extended to the accumulator width.
    always_comb begin
        prod     = fm_rdata * wq;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Stages 1 and 2: capture the issue, then accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[1] <= 1'b0;
            v_q[2] <= 1'b0;
            idx_q[1] <= '0;
            idx_q[2] <= '0;
            old_q <= '0;
            acc_q[2] <= '0;
        end else begin
            v_q[1]   <= issue_v;
            idx_q[1] <= issue_idx;
            old_q    <= old_acc;
            v_q[2]   <= v_q[1];
            idx_q[2] <= idx_q[1];
            acc_q[2] <= old_q + prod_ext;
        end
    end

    // Remaining delay stages up to the write-back latency.
    for (genvar gs = 3; gs <= LAT; gs++) begin : g_delay
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[gs]   <= 1'b0;
                idx_q[gs] <= '0;
                acc_q[gs] <= '0;
            end else begin
                v_q[gs]   <= v_q[gs-1];
                idx_q[gs] <= idx_q[gs-1];
                acc_q[gs] <= acc_q[gs-1];
            end
        end
    end

    // Write-back port and pipeline occupancy.
    always_comb begin
        wr_v   = v_q[LAT];
        wr_idx = idx_q[LAT];
        wr_acc = acc_q[LAT];
        busy   = 1'b0;
        for (int i = 1; i <= LAT; i++) busy = busy | v_q[i];
    end

    // No issue may read an entry that an in-flight stage still owns.
    for (genvar hs = 1; hs <= LAT; hs++) begin : g_hazard
        assert_no_raw_hazard_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_v && v_q[hs]) |-> (idx_q[hs] != issue_idx));
    end
endmodule

// File: rtl/conv_relu_sat.sv
// Write-out arithmetic: adds the channel bias to a partial sum, forces
// non-positive results to zero and clips large ones to the output range.
module conv_relu_sat #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]         acc,
    input  logic signed [DATA_W-1:0] bias,
    output logic [DATA_W-1:0]        result
);
    localparam logic signed [ACC_W-1:0] MAX_POS = ACC_W'((1 << (DATA_W-1)) - 1);
    logic signed [ACC_W-1:0] sum;

    // Bias, rectify, saturate.
    always_comb begin
        sum = $signed(acc) + {{(ACC_W-DATA_W){bias[DATA_W-1]}}, bias};
        if (sum <= 0)
            result = '0;
        else if (sum > MAX_POS)
            result = MAX_POS[DATA_W-1:0];
        else
            result = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/conv_sweep_ctrl.sv
// Loop sequencer. Runs output channel, input channel, kernel row, kernel
// column, output column, output row (innermost). Fetches each weight once per
// tap, stalls a sweep start until the pipeline has retired the prior update of
// the same entry, then writes the channel out. Assumes 1 <= k <= in_h, in_w,
// out_h*out_w <= MAX_PIX and synchronous read memories of latency one.
module conv_sweep_ctrl
    import conv_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIM_W   = 8,
    parameter int MAX_PIX = 64,
    parameter int LAT     = 14,
    parameter int FM_AW   = 16,
    parameter int WT_AW   = 16,
    parameter int OUT_AW  = 16,
    localparam int IDX_W  = $clog2(MAX_PIX),
    localparam int PIX_W  = $clog2(MAX_PIX + 1),
    localparam int AGE_W  = $clog2(LAT + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_in_h,
    input  logic [DIM_W-1:0]  cfg_in_w,
    input  logic [DIM_W-1:0]  cfg_in_ch,
    input  logic [DIM_W-1:0]  cfg_k,
    input  logic [DIM_W-1:0]  cfg_out_ch,
    input  logic              pipe_busy,
    input  logic [DATA_W-1:0] wt_rdata,
    input  logic [DATA_W-1:0] bias_rdata,
    output logic [FM_AW-1:0]  fm_addr,
    output logic [WT_AW-1:0]  wt_addr,
    output logic [DIM_W-1:0]  bias_addr,
    output logic [DATA_W-1:0] wq,
    output logic [DATA_W-1:0] bq,
    output logic              buf_clear,
    output logic              issue_v,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_we,
    output logic [OUT_AW-1:0] out_addr,
    output logic              done
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_OK  = AGE_W'(LAT + 1);

    eng_state_t       st;
    logic [DIM_W-1:0] ih_q, iw_q, ich_q, k_q, och_q;
    logic [DIM_W-1:0] oc, ic, ky, kx, col, row;
    logic [IDX_W-1:0] oidx;
    logic [AGE_W-1:0] age;
    logic [DIM_W-1:0] oh, ow;
    logic [PIX_W-1:0] npix;
    logic             row_last, col_last, kx_last, ky_last, ic_last, oc_last;
    logic             first_pos, gap_ok, oidx_last;

    // Derived plane shape and loop-end flags.
    always_comb begin
        oh        = ih_q - k_q + DIM_W'(1);
        ow        = iw_q - k_q + DIM_W'(1);
        npix      = PIX_W'(oh) * PIX_W'(ow);
        row_last  = (row == oh - DIM_W'(1));
        col_last  = (col == ow - DIM_W'(1));
        kx_last   = (kx == k_q - DIM_W'(1));
        ky_last   = (ky == k_q - DIM_W'(1));
        ic_last   = (ic == ich_q - DIM_W'(1));
        oc_last   = (oc == och_q - DIM_W'(1));
        oidx_last = (PIX_W'(oidx) == npix - PIX_W'(1));
        first_pos = (row == '0) && (col == '0);
        gap_ok    = !first_pos || (age >= AGE_OK);
    end

    // Memory addresses and issue signals for the current loop position.
    always_comb begin
        fm_addr   = (FM_AW'(ic) * FM_AW'(ih_q) + FM_AW'(row) + FM_AW'(ky)) * FM_AW'(iw_q)
                    + FM_AW'(col) + FM_AW'(kx);
        wt_addr   = ((WT_AW'(oc) * WT_AW'(ich_q) + WT_AW'(ic)) * WT_AW'(k_q) + WT_AW'(ky))
                    * WT_AW'(k_q) + WT_AW'(kx);
        bias_addr = oc;
        issue_idx = IDX_W'(row) * IDX_W'(ow) + IDX_W'(col);
        issue_v   = (st == ST_SWEEP) && gap_ok;
        buf_clear = (st == ST_CLEAR);
        out_idx   = oidx;
        out_we    = (st == ST_WRITE);
        out_addr  = OUT_AW'(oc) * OUT_AW'(npix) + OUT_AW'(oidx);
        done      = (st == ST_DONE);
    end

    // Sequencer: state, loop counters, configuration and operand latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            {ih_q, iw_q, ich_q, k_q, och_q} <= '0;
            {oc, ic, ky, kx, col, row} <= '0;
            oidx <= '0;
            age  <= AGE_MAX;
            wq   <= '0;
            bq   <= '0;
        end else begin
            if (issue_v && first_pos) age <= AGE_W'(1);
            else if (age != AGE_MAX)  age <= age + AGE_W'(1);
            unique case (st)
                ST_IDLE: if (start) begin
                    ih_q  <= cfg_in_h;
                    iw_q  <= cfg_in_w;
                    ich_q <= cfg_in_ch;
                    k_q   <= cfg_k;
                    och_q <= cfg_out_ch;
                    oc    <= '0;
                    st    <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    {ic, ky, kx, col, row} <= '0;
                    oidx <= '0;
                    age  <= AGE_MAX;
                    st   <= ST_WADDR;
                end
                ST_WADDR:  st <= ST_WLATCH;
                ST_WLATCH: begin
                    wq <= wt_rdata;
                    st <= ST_SWEEP;
                end
                ST_SWEEP: if (issue_v) begin
                    if (!row_last) row <= row + DIM_W'(1);
                    else begin
                        row <= '0;
                        if (!col_last) col <= col + DIM_W'(1);
                        else begin
                            col <= '0;
                            st  <= ST_WADDR;
                            if (!kx_last) kx <= kx + DIM_W'(1);
                            else begin
                                kx <= '0;
                                if (!ky_last) ky <= ky + DIM_W'(1);
                                else begin
                                    ky <= '0;
                                    if (!ic_last) ic <= ic + DIM_W'(1);
                                    else begin
                                        ic <= '0;
                                        st <= ST_DRAIN;
                                    end
                                end
                            end
                        end
                    end
                end
                ST_DRAIN:  if (!pipe_busy) st <= ST_BADDR;
                ST_BADDR:  st <= ST_BLATCH;
                ST_BLATCH: begin
                    bq <= bias_rdata;
                    st <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (!oidx_last) oidx <= oidx + IDX_W'(1);
                    else begin
                        oidx <= '0;
                        if (oc_last) st <= ST_DONE;
                        else begin
                            oc <= oc + DIM_W'(1);
                            st <= ST_CLEAR;
                        end
                    end
                end
                ST_DONE:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // A busy engine must keep the shape it captured at start.
    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_DONE) |=> ($stable(k_q) && $stable(och_q) && $stable(ih_q)));
    // Writes stay inside the layer's output range.
    assert_out_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_addr < OUT_AW'(och_q) * OUT_AW'(npix)));
    // The buffer is only cleared with the pipeline empty.
    assert_clear_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |-> !pipe_busy);
endmodule

// File: rtl/conv_sweep_engine.sv
// Top of the channel-sweep convolution engine: sequencer, MAC pipeline,
// partial-sum buffer and write-out arithmetic. Stride 1, no padding.
module conv_sweep_engine #(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int DIM_W   = 8,
    parameter int MAX_PIX = 64,
    parameter int LAT     = 14,
    parameter int FM_AW   = 16,
    parameter int WT_AW   = 16,
    parameter int OUT_AW  = 16,
    localparam int IDX_W  = $clog2(MAX_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_in_h,
    input  logic [DIM_W-1:0]  cfg_in_w,
    input  logic [DIM_W-1:0]  cfg_in_ch,
    input  logic [DIM_W-1:0]  cfg_k,
    input  logic [DIM_W-1:0]  cfg_out_ch,
    output logic [FM_AW-1:0]  fm_addr,
    input  logic [DATA_W-1:0] fm_rdata,
    output logic [WT_AW-1:0]  wt_addr,
    input  logic [DATA_W-1:0] wt_rdata,
    output logic [DIM_W-1:0]  bias_addr,
    input  logic [DATA_W-1:0] bias_rdata,
    output logic              out_we,
    output logic [OUT_AW-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              done
);
    logic              pipe_busy, buf_clear, issue_v, wr_v;
    logic [IDX_W-1:0]  issue_idx, out_idx, wr_idx;
    logic [ACC_W-1:0]  old_acc, wr_acc, out_acc;
    logic [DATA_W-1:0] wq, bq;

    conv_sweep_ctrl #(
        .DATA_W(DATA_W), .DIM_W(DIM_W), .MAX_PIX(MAX_PIX), .LAT(LAT),
        .FM_AW(FM_AW), .WT_AW(WT_AW), .OUT_AW(OUT_AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_in_h(cfg_in_h), .cfg_in_w(cfg_in_w), .cfg_in_ch(cfg_in_ch),
        .cfg_k(cfg_k), .cfg_out_ch(cfg_out_ch),
        .pipe_busy(pipe_busy), .wt_rdata(wt_rdata), .bias_rdata(bias_rdata),
        .fm_addr(fm_addr), .wt_addr(wt_addr), .bias_addr(bias_addr),
        .wq(wq), .bq(bq), .buf_clear(buf_clear),
        .issue_v(issue_v), .issue_idx(issue_idx), .out_idx(out_idx),
        .out_we(out_we), .out_addr(out_addr), .done(done)
    );

    conv_mac_pipe #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .MAX_PIX(MAX_PIX), .LAT(LAT)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .issue_v(issue_v), .issue_idx(issue_idx),
        .old_acc(old_acc), .fm_rdata(fm_rdata), .wq(wq),
        .wr_v(wr_v), .wr_idx(wr_idx), .wr_acc(wr_acc), .busy(pipe_busy)
    );

    conv_psum_buf #(
        .ACC_W(ACC_W), .MAX_PIX(MAX_PIX)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear),
        .wr_v(wr_v), .wr_idx(wr_idx), .wr_acc(wr_acc),
        .rda_idx(issue_idx), .rda_acc(old_acc),
        .rdb_idx(out_idx), .rdb_acc(out_acc)
    );

    conv_relu_sat #(
        .DATA_W(DATA_W), .ACC_W(ACC_W)
    ) u_relu (
        .acc(out_acc), .bias(bq), .result(out_wdata)
    );

    // Rectified output is never negative.
    assert_relu_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> !out_wdata[DATA_W-1]);
    // Done lasts exactly one clock.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // No write strobe in the done cycle.
    assert_done_after_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_we);
endmodule

// File: tb/conv_sweep_engine_bench.sv
// Self-checking bench: random and directed layers compared against a
// bench-side reference convolution.
module conv_sweep_engine_bench;
    localparam int LAT = 14;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, out_we, done, clr_cnt;
    logic [7:0]  cfg_in_h, cfg_in_w, cfg_in_ch, cfg_k, cfg_out_ch, bias_addr;
    logic [15:0] fm_addr, wt_addr, out_addr, out_wdata;
    logic [15:0] fm_rdata, wt_rdata, bias_rdata;

    logic signed [15:0] fm_mem [0:1023];
    logic signed [15:0] wt_mem [0:1023];
    logic signed [15:0] bias_mem [0:63];
    logic [15:0] out_mem [0:1023];
    int wr_cnt [0:1023];
    int exp_mem [0:1023];
    int done_cnt, cyc, n_checks, n_fail;

    conv_sweep_engine u_conv_sweep_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_in_h(cfg_in_h), .cfg_in_w(cfg_in_w), .cfg_in_ch(cfg_in_ch),
        .cfg_k(cfg_k), .cfg_out_ch(cfg_out_ch),
        .fm_addr(fm_addr), .fm_rdata(fm_rdata),
        .wt_addr(wt_addr), .wt_rdata(wt_rdata),
        .bias_addr(bias_addr), .bias_rdata(bias_rdata),
        .out_we(out_we), .out_addr(out_addr), .out_wdata(out_wdata), .done(done)
    );

    // Memory models (read latency one, R10) and bench counters.
    always @(posedge clk) begin
        fm_rdata   <= fm_mem[fm_addr[9:0]];
        wt_rdata   <= wt_mem[wt_addr[9:0]];
        bias_rdata <= bias_mem[bias_addr[5:0]];
        cyc <= cyc + 1;
        if (clr_cnt) begin
            for (int i = 0; i < 1024; i++) wr_cnt[i] <= 0;
            done_cnt <= 0;
        end else begin
            if (out_we) begin
                out_mem[out_addr[9:0]] <= out_wdata;
                wr_cnt[out_addr[9:0]]  <= wr_cnt[out_addr[9:0]] + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic fill(int ih, int iw, int ich, int k, int och, int afm, int aw, int ab);
        for (int i = 0; i < ich*ih*iw; i++) fm_mem[i] = 16'(rnd(-afm, afm));
        for (int i = 0; i < och*ich*k*k; i++) wt_mem[i] = 16'(rnd(-aw, aw));
        for (int i = 0; i < och; i++) bias_mem[i] = 16'(rnd(-ab, ab));
    endtask

    // Reference: R2 addressing, R6 rectifier, R7 saturation.
    task automatic reference(int ih, int iw, int ich, int k, int och);
        int oh, ow, np;
        longint acc;
        oh = ih - k + 1; ow = iw - k + 1; np = oh * ow;
        for (int oc = 0; oc < och; oc++)
            for (int r = 0; r < oh; r++)
                for (int c = 0; c < ow; c++) begin
                    acc = 0;
                    for (int ic = 0; ic < ich; ic++)
                        for (int ky = 0; ky < k; ky++)
                            for (int kx = 0; kx < k; kx++)
                                acc += longint'(fm_mem[(ic*ih + r + ky)*iw + c + kx])
                                     * longint'(wt_mem[((oc*ich + ic)*k + ky)*k + kx]);
                    acc += longint'(bias_mem[oc]);
                    if (acc <= 0) acc = 0;
                    if (acc > 32767) acc = 32767;
                    exp_mem[oc*np + r*ow + c] = int'(acc);
                end
    endtask

    task automatic run_layer(int ih, int iw, int ich, int k, int och, string tag,
                             bit poke, int exp_cyc);
        int np, c0, wd;
        np = (ih - k + 1) * (iw - k + 1);
        reference(ih, iw, ich, k, och);
        @(negedge clk); clr_cnt = 1'b1;
        @(negedge clk); clr_cnt = 1'b0;
        cfg_in_h = 8'(ih); cfg_in_w = 8'(iw); cfg_in_ch = 8'(ich);
        cfg_k = 8'(k); cfg_out_ch = 8'(och); start = 1'b1;
        c0 = cyc;
        @(negedge clk); start = 1'b0;
        wd = 0;
        while (done !== 1'b1 && wd < 50000) begin
            if (poke && wd == 20) begin
                start = 1'b1; cfg_k = 8'd1; cfg_out_ch = 8'd7; cfg_in_h = 8'd9;
            end else if (poke && wd == 21) begin
                start = 1'b0;
            end
            @(negedge clk);
            wd++;
        end
        if (wd >= 50000) begin
            check(1'b0, "watchdog expired", wd, 50000);
            return;
        end
        if (exp_cyc > 0) check(cyc - c0 == exp_cyc, "R4 cycle count", cyc - c0, exp_cyc);
        // R9: done one clock, at the cycle after the last write.
        @(negedge clk);
        check(done == 1'b0, "R9 done width", int'(done), 0);
        repeat (2) @(negedge clk);
        check(done_cnt == 1, {tag, " R9/R8 done count"}, done_cnt, 1);
        for (int a = 0; a < och*np; a++) begin
            check(wr_cnt[a] == 1, {tag, " R9 write once"}, wr_cnt[a], 1);
            check(int'(out_mem[a]) == exp_mem[a], tag, int'(out_mem[a]), exp_mem[a]);
        end
    endtask

    initial begin
        void'($urandom(20240611));
        n_checks = 0; n_fail = 0; cyc = 0; done_cnt = 0;
        rst_n = 1'b0; start = 1'b0; clr_cnt = 1'b0;
        cfg_in_h = '0; cfg_in_w = '0; cfg_in_ch = '0; cfg_k = '0; cfg_out_ch = '0;
        for (int i = 0; i < 1024; i++) begin
            fm_mem[i] = '0; wt_mem[i] = '0; out_mem[i] = '0;
        end
        for (int i = 0; i < 64; i++) bias_mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(out_we == 1'b0, "R1 out_we after reset", int'(out_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && out_we == 1'b0, "R1 idle after release", int'(done), 0);

        // Large plane, P=64: exact cycle count (R4), addressing (R2), R10 memories.
        fill(10, 10, 1, 3, 1, 100, 50, 1500);
        run_layer(10, 10, 1, 3, 1, "R2/R6 plane64", 1'b0,
                  1 + (1 + 9*(64+2) + LAT + 1 + 2 + 64));
        // Small plane with several channels: stall path (R5), per-channel clear (R3).
        fill(5, 5, 2, 3, 3, 120, 60, 2000);
        run_layer(5, 5, 2, 3, 3, "R5/R3 plane9", 1'b0, -1);
        // Single-pixel plane, worst-case stall (R5).
        fill(3, 3, 2, 3, 2, 120, 60, 500);
        run_layer(3, 3, 2, 3, 2, "R5 plane1", 1'b0, -1);
        // 1x1 kernel, multi input channel (R2).
        fill(4, 4, 3, 1, 2, 120, 60, 300);
        run_layer(4, 4, 3, 1, 2, "R2 k1", 1'b0, -1);

        // Positive saturation (R7).
        for (int i = 0; i < 32; i++) fm_mem[i] = 16'sd32767;
        for (int i = 0; i < 8; i++) wt_mem[i] = 16'sd32767;
        bias_mem[0] = 16'sd100;
        run_layer(4, 4, 2, 2, 1, "R7 saturate high", 1'b0, -1);
        // Large negative sum rectified to zero (R6).
        for (int i = 0; i < 8; i++) wt_mem[i] = -16'sd32767;
        run_layer(4, 4, 2, 2, 1, "R6 rectify negative", 1'b0, -1);
        // Zero sum with zero bias gives zero (R6 boundary).
        for (int i = 0; i < 8; i++) wt_mem[i] = 16'sd0;
        bias_mem[0] = 16'sd0;
        run_layer(4, 4, 2, 2, 1, "R6 zero sum", 1'b0, -1);

        // Start with a different shape while busy is ignored (R8).
        fill(6, 6, 2, 3, 2, 100, 50, 800);
        run_layer(6, 6, 2, 3, 2, "R8 start while busy", 1'b1, -1);

        // Constrained random layers (R2, R3, R5, R6).
        for (int t = 0; t < 8; t++) begin
            int ih, iw, k, ich, och;
            ih = rnd(2, 8); iw = rnd(2, 8);
            k = rnd(1, (ih < iw) ? ih : iw);
            ich = rnd(1, 3); och = rnd(1, 3);
            fill(ih, iw, ich, k, och, 128, 64, 3000);
            run_layer(ih, iw, ich, k, och, "R2/R3/R5 random", 1'b0, -1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule